// File: doc/BRIEF.md
# Register-Controlled Clock Gate

This block gates a parent clock under the control of one bit held in a 32-bit control register. Software, or a local controller, writes the register through a plain synchronous port with no address: every write targets the single register, and the register contents are always visible on the read bus. The gated output copies the parent clock while the selected bit asks for the clock to run. Otherwise the output is held low.

Three build-time choices shape the block. The first is the index of the controlling bit. The second is the sense of that bit: with the normal sense a 1 runs the clock, and with the inverted sense a 1 stops it. The third is the write format. A plain write replaces the whole register. A masked write keeps the settings in the lower half of the register and uses each upper-half bit as the write strobe for the lower bit 16 places below it.

The enable decision is re-timed onto the falling edge of the parent clock. The gate therefore opens or closes only while the parent clock is low, and every high pulse on the output is a whole parent high phase.

Top module: `clkgate_reg`

## Requirements
- R1: While reset is asserted the register reads 0. The gated output is therefore stopped with the normal sense and running with the inverted sense.
- R2: With the normal sense, a 1 in control bit GATE_BIT makes the output follow the parent clock, and a 0 holds the output low.
- R3: With the inverted sense, a 1 in control bit GATE_BIT holds the output low, and a 0 lets it follow the parent clock.
- R4: In masked-write mode, a write updates lower bit i (i < 16) only when wr_data[i+16] is 1. A lower bit whose strobe is 0 keeps its value.
- R5: In masked-write mode, read bits 31..16 are always 0.
- R6: In plain-write mode, a write stores all 32 bits of wr_data, and they are read back unchanged from the next cycle on.
- R7: The output is never high while the parent clock is low. Each output high pulse starts with a parent rising edge and ends with the following parent falling edge.
- R8: A write sampled at parent rising edge k leaves the output unchanged for the high phase that edge starts. The new gate state applies from the high phase that starts at rising edge k+1.
- R9: With no write in the previous cycle, the control bit read back (combined with the sense) tells whether the output is running.
- R10: A write that leaves the control bit unchanged, or a cycle with no write, does not interrupt or start the output clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock; also clocks the register |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write value (masked mode: strobes in bits 31..16, settings in 15..0) |
| rd_data | output | 32 | Current register contents |
| gated_clk | output | 1 | Gated copy of clk |

## Verification
Two events can fall in the same parent cycle: a register write on the rising edge, and the falling-edge capture of the gate state. On that falling edge the gate picks up the value that was just written. The bench provokes this by writing alternating values on every cycle with the write strobe held high, and by writing while the output is running. A behavioural model is stepped on both clock edges and predicts the readback, the high-phase level and the low-phase level for every cycle. Separate monitors on each output edge check that an output edge coincides with the matching parent edge, so the bench would catch a clipped pulse.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  typedef enum logic {
    WR_PLAIN  = 1'b0,
    WR_MASKED = 1'b1
  } wr_mode_e;
endpackage

// File: rtl/cg_ctrl_reg.sv
module cg_ctrl_reg
  import clkgate_pkg::*;
#(
  parameter int       REG_W   = 32,
  parameter wr_mode_e WR_MODE = WR_PLAIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);
  localparam int HALF = REG_W / 2;

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] ctrl_d;

  generate
    if (WR_MODE == WR_MASKED) begin : g_masked
      for (genvar i = 0; i < HALF; i++) begin : g_bit
        assign ctrl_d[i] = (wr_en && wr_data[i+HALF]) ? wr_data[i] : ctrl_q[i];
      end
      assign ctrl_d[REG_W-1:HALF] = '0;
    end else begin : g_plain
      assign ctrl_d = wr_en ? wr_data : ctrl_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign rd_data = ctrl_q;
endmodule

// File: rtl/cg_polarity.sv
module cg_polarity #(
  parameter bit INVERT = 1'b0
) (
  input  logic ctrl_bit,
  output logic run_req
);
  generate
    if (INVERT) begin : g_inv
      assign run_req = ~ctrl_bit;
    end else begin : g_dir
      assign run_req = ctrl_bit;
    end
  endgenerate
endmodule

// File: rtl/cg_gate_cell.sv
module cg_gate_cell #(
  parameter bit RESET_RUN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  output logic gated_clk
);
  logic run_q;

  // Capture on the falling edge: the enable only moves while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= RESET_RUN;
    else        run_q <= run_req;
  end

  assign gated_clk = clk & run_q;
endmodule

// File: rtl/clkgate_reg.sv
module clkgate_reg
  import clkgate_pkg::*;
#(
  parameter int       REG_W    = 32,
  parameter int       GATE_BIT = 0,
  parameter bit       INVERT   = 1'b0,
  parameter wr_mode_e WR_MODE  = WR_PLAIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             gated_clk
);
  localparam int HALF      = REG_W / 2;
  localparam int BIT_LIMIT = (WR_MODE == WR_MASKED) ? HALF : REG_W;

  generate
    if (GATE_BIT >= BIT_LIMIT || GATE_BIT < 0) begin : g_bad_bit
      $error("clkgate_reg: GATE_BIT outside the settable field");
    end
  endgenerate

  logic ctrl_bit;
  logic run_req;

  cg_ctrl_reg #(
    .REG_W  (REG_W),
    .WR_MODE(WR_MODE)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data)
  );

  assign ctrl_bit = rd_data[GATE_BIT];

  cg_polarity #(
    .INVERT(INVERT)
  ) u_pol (
    .ctrl_bit(ctrl_bit),
    .run_req (run_req)
  );

  cg_gate_cell #(
    .RESET_RUN(INVERT)
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_req  (run_req),
    .gated_clk(gated_clk)
  );
endmodule

// File: rtl/clkgate_reg_chk.sv
module clkgate_reg_chk
  import clkgate_pkg::*;
#(
  parameter int       REG_W    = 32,
  parameter int       GATE_BIT = 0,
  parameter bit       INVERT   = 1'b0,
  parameter wr_mode_e WR_MODE  = WR_PLAIN
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             gated_clk
);
  localparam int HALF      = REG_W / 2;
  localparam bit IS_MASKED = (WR_MODE == WR_MASKED);
  localparam int MASK_IDX  = IS_MASKED ? GATE_BIT + HALF : GATE_BIT;

  // R6
  plain_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_MASKED && wr_en) |=> (rd_data == $past(wr_data)));

  // R4
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_MASKED && wr_en && !wr_data[MASK_IDX]) |=> $stable(rd_data[GATE_BIT]));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    IS_MASKED |-> (rd_data[REG_W-1:HALF] == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  // R7
  low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gated_clk);

  // R8
  high_phase_chk: assert property (@(negedge clk) disable iff (!rst_n)
    gated_clk == ($past(rd_data[GATE_BIT]) ^ INVERT));
endmodule

bind clkgate_reg clkgate_reg_chk #(
  .REG_W   (REG_W),
  .GATE_BIT(GATE_BIT),
  .INVERT  (INVERT),
  .WR_MODE (WR_MODE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .gated_clk(gated_clk)
);

// File: tb/clkgate_reg_tb.sv
module clkgate_reg_tb;
  import clkgate_pkg::*;

  localparam int PERIOD = 10;
  localparam int GB [3] = '{3, 5, 2};
  localparam bit IV [3] = '{1'b0, 1'b1, 1'b0};
  localparam bit MK [3] = '{1'b0, 1'b0, 1'b1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd [3];
  logic        gco [3];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  clkgate_reg #(.GATE_BIT(3), .INVERT(1'b0), .WR_MODE(WR_PLAIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd[0]), .gated_clk(gco[0]));
  clkgate_reg #(.GATE_BIT(5), .INVERT(1'b1), .WR_MODE(WR_PLAIN)) u_inv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd[1]), .gated_clk(gco[1]));
  clkgate_reg #(.GATE_BIT(2), .INVERT(1'b0), .WR_MODE(WR_MASKED)) u_msk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd[2]), .gated_clk(gco[2]));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] reg_m [3];
  logic        en_m  [3];

  function automatic logic [31:0] next_val(input int i, input logic [31:0] cur,
                                           input logic [31:0] wd);
    logic [31:0] nv;
    if (!MK[i]) return wd;
    nv = cur;
    for (int b = 0; b < 16; b++) if (wd[b+16]) nv[b] = wd[b];
    nv[31:16] = '0;
    return nv;
  endfunction

  always @(posedge clk or negedge rst_n)
    for (int i = 0; i < 3; i++) begin
      if (!rst_n)     reg_m[i] <= '0;
      else if (wr_en) reg_m[i] <= next_val(i, reg_m[i], wr_data);
    end

  always @(negedge clk or negedge rst_n)
    for (int i = 0; i < 3; i++) begin
      if (!rst_n) en_m[i] <= IV[i];
      else        en_m[i] <= reg_m[i][GB[i]] ^ IV[i];
    end

  // Per-cycle comparison: high phase
  always @(posedge clk) begin
    #2;
    if (rst_n && !done)
      for (int i = 0; i < 3; i++) begin
        check(rd[i] == reg_m[i], MK[i] ? "R4/R5 masked readback" : "R6 plain readback",
              rd[i], reg_m[i]);
        check(gco[i] == en_m[i], IV[i] ? "R3/R8 inverted gate high phase"
                                       : "R2/R8 gate high phase",
              {31'd0, gco[i]}, {31'd0, en_m[i]});
      end
  end

  // Per-cycle comparison: low phase
  always @(negedge clk) begin
    #2;
    if (rst_n && !done)
      for (int i = 0; i < 3; i++)
        check(gco[i] == 1'b0, "R7 low phase", {31'd0, gco[i]}, 32'd0);
  end

  // Glitch monitors (R7): output edges must coincide with matching parent edges
  always @(posedge gco[0]) if (rst_n) check(clk == 1'b1, "R7 rise u_dut", {31'd0, clk}, 32'd1);
  always @(negedge gco[0]) if (rst_n) check(clk == 1'b0, "R7 fall u_dut", {31'd0, clk}, 32'd0);
  always @(posedge gco[1]) if (rst_n) check(clk == 1'b1, "R7 rise u_inv", {31'd0, clk}, 32'd1);
  always @(negedge gco[1]) if (rst_n) check(clk == 1'b0, "R7 fall u_inv", {31'd0, clk}, 32'd0);
  always @(posedge gco[2]) if (rst_n) check(clk == 1'b1, "R7 rise u_msk", {31'd0, clk}, 32'd1);
  always @(negedge gco[2]) if (rst_n) check(clk == 1'b0, "R7 fall u_msk", {31'd0, clk}, 32'd0);

  task automatic wr(input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic hi_phase();
    @(posedge clk); #3;
  endtask

  initial begin : watchdog
    #(PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    // R1: reset state during reset
    #3;
    check(rd[0] == 32'd0, "R1 reset readback", rd[0], 32'd0);
    check(gco[0] == 1'b0, "R1 normal sense stopped", {31'd0, gco[0]}, 32'd0);
    check(gco[1] == 1'b1, "R1 inverted sense running", {31'd0, gco[1]}, 32'd1);
    @(posedge clk); #1 rst_n = 1'b1;
    hi_phase();
    check(rd[2] == 32'd0, "R1 reset readback masked", rd[2], 32'd0);

    // R8: write takes effect one high phase later
    @(negedge clk); #1 wr_en = 1'b1; wr_data = 32'h0000_0008;
    hi_phase();
    check(gco[0] == 1'b0, "R8 same high phase unchanged", {31'd0, gco[0]}, 32'd0);
    @(negedge clk); #1 wr_en = 1'b0;
    hi_phase();
    check(gco[0] == 1'b1, "R8 next high phase running", {31'd0, gco[0]}, 32'd1);
    // R9: readback reflects running state
    check(gco[0] == rd[0][3], "R9 readback matches output", {31'd0, gco[0]}, {31'd0, rd[0][3]});
    // R4: no strobes, masked register untouched
    check(rd[2] == 32'd0, "R4 unstrobed write ignored", rd[2], 32'd0);

    // R10: write leaving the control bit set
    wr(32'h0000_0009);
    hi_phase();
    check(gco[0] == 1'b1, "R10 other bits no effect", {31'd0, gco[0]}, 32'd1);
    hi_phase();
    check(gco[0] == 1'b1, "R10 idle no effect", {31'd0, gco[0]}, 32'd1);

    wr(32'hFFFF_FFF7);
    hi_phase(); hi_phase();
    check(rd[2] == 32'h0000_FFF7, "R5 masked upper reads zero", rd[2], 32'h0000_FFF7);
    check(gco[2] == 1'b1, "R4 strobed bit set", {31'd0, gco[2]}, 32'd1);
    check(gco[1] == 1'b0, "R3 inverted set stops", {31'd0, gco[1]}, 32'd0);
    check(gco[0] == 1'b0, "R2 cleared stops", {31'd0, gco[0]}, 32'd0);
    check(rd[0] == 32'hFFFF_FFF7, "R6 full word stored", rd[0], 32'hFFFF_FFF7);

    wr(32'h0004_0000);
    hi_phase(); hi_phase();
    check(rd[2] == 32'h0000_FFF3, "R4 single strobe clears bit", rd[2], 32'h0000_FFF3);
    check(gco[2] == 1'b0, "R4 gate stopped", {31'd0, gco[2]}, 32'd0);
    check(gco[1] == 1'b1, "R3 inverted clear runs", {31'd0, gco[1]}, 32'd1);

    wr(32'h0000_0004);
    hi_phase(); hi_phase();
    check(rd[2] == 32'h0000_FFF3, "R4 data without strobe ignored", rd[2], 32'h0000_FFF3);
    check(gco[2] == 1'b0, "R4 gate still stopped", {31'd0, gco[2]}, 32'd0);

    // Back-to-back toggling writes: register update meets falling-edge capture
    @(negedge clk); #1 wr_en = 1'b1;
    for (int k = 0; k < 12; k++) begin
      wr_data = k[0] ? 32'h0024_002C : 32'h0004_0000;
      @(negedge clk); #1;
    end
    wr_en = 1'b0;

    // Pseudo-random traffic, checked every cycle by the model
    lfsr = 32'hACE1_2345;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      wr_en = lfsr[7] & lfsr[13];
      wr_data = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      @(negedge clk); #1;
    end
    wr_en = 1'b0;
    repeat (4) @(posedge clk);
    #4;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule